// File: doc/BRIEF.md
# GPIO Port Control Register Bank

This block keeps the per-pin configuration of a general-purpose I/O port. The port is split into banks of equal width. For every pin it stores a direction bit, an output level, a float (three-state) bit, an input inversion bit and a pull-up enable. From these it drives three per-pin outputs toward the pad ring: the output value, the output enable and the pull-up enable. The pad circuits, level shifting and resistors are outside the block.

A serial slave, or any other register master, reaches the bank through a simple word-wide port. A write strobe with an address and a data byte updates one register on the clock edge. A read strobe with an address returns one register in the same cycle. One read-only address per bank returns the pin state. For an input pin the state is the synchronised pad input, inverted where the inversion bit is set. For an output pin it is the last output level written, whatever the pad is doing.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every pin is an input with the pull-up off: `pad_oe` and `pull_en` are all zero and `pad_out` is all ones. Direction and level registers read back all ones. Float, inversion and pull-up registers read back zero.
- R2: The register address is `kind*NUM_BANKS + bank`. The kind codes are: state 0, level 1, direction 2, float 3, inversion 4, pull-up 5. Bank 0 holds pins 7:0 and bank 1 holds pins 15:8. Bit n of a bank register belongs to pin `8*bank + n`, so the MSB is the highest pin of the bank. A written value reads back unchanged.
- R3: A direction bit of 0 makes the pin an output and 1 makes it an input. `pad_oe` of a pin is 1 exactly when the pin is an output and its float bit is 0.
- R4: A float bit of 1 clears `pad_oe` of an output pin and leaves `pad_out` unchanged.
- R5: `pad_out` equals the level register. Reading the level register returns the last written value, whether or not the pin is driven.
- R6: For an input pin, the state register returns the pad input XOR the inversion bit. A pad change is not visible after one rising clock edge and is visible after the second.
- R7: For an output pin, the state register returns the level bit, independent of the pad input and the inversion bit.
- R8: `pull_en` equals the pull-up register, bit for bit.
- R9: Writes to the state addresses and to unmapped addresses (12 to 15) change no output and no register. Reads of unmapped addresses return 0. `rdata` is 0 whenever `rd_en` is low.
- R10: A write lands on the rising edge where `wr_en` is high. A read of the same address in that cycle returns the old value, and the new value appears from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (4) | Register address |
| wdata | input | BANK_W (8) | Write data |
| rdata | output | BANK_W (8) | Read data, zero when not reading |
| pad_in | input | NUM_BANKS*BANK_W (16) | Asynchronous pad inputs |
| pad_out | output | NUM_BANKS*BANK_W (16) | Per-pin output value |
| pad_oe | output | NUM_BANKS*BANK_W (16) | Per-pin output enable |
| pull_en | output | NUM_BANKS*BANK_W (16) | Per-pin pull-up enable |

## Verification
A write and a read can hit the same register in one cycle. The bench raises both strobes together on the level register of the upper bank. It samples `rdata` before the edge and expects the old byte. It samples again after the edge and expects the new byte on both `rdata` and `pad_out`. A pad change can also meet a state read in the same window. The bench changes `pad_in` and reads the state one edge later and two edges later, and judges the read by the two-stage synchroniser latency.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   // register kinds; the address of a register is kind*NUM_BANKS + bank
   typedef enum logic [2:0] {
      KIND_STATE = 3'd0,
      KIND_LEVEL = 3'd1,
      KIND_DIR   = 3'd2,
      KIND_FLOAT = 3'd3,
      KIND_INV   = 3'd4,
      KIND_PULL  = 3'd5
   } reg_kind_e;

   localparam int NUM_KINDS = 6;

   function automatic int reg_addr(input int kind, input int bank, input int num_banks);
      return kind * num_banks + bank;
   endfunction

   // level and direction come up as all ones, the rest as zero
   function automatic bit resets_high(input int kind);
      return (kind == int'(KIND_LEVEL)) || (kind == int'(KIND_DIR));
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_sync: WIDTH must be positive");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= async_in;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg #(
   parameter int               WIDTH     = 8,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RESET_VAL;
      end else if (we) begin
         q <= wdata;
      end
   end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_port_pkg::*;
#(
   parameter int BANK_W = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NUM_KINDS-1:1]                we_kind,
   input  logic [BANK_W-1:0]                   wdata,
   input  logic [BANK_W-1:0]                   pin_sync,
   output logic [NUM_KINDS-1:0][BANK_W-1:0]    view
);

   logic [BANK_W-1:0] level_q, dir_q, inv_q;
   logic [BANK_W-1:0] state_val;

   for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
      if (k == int'(KIND_STATE)) begin : g_state
         assign view[k] = state_val;
      end else begin : g_reg
         gpio_cfg_reg #(
            .WIDTH     (BANK_W),
            .RESET_VAL (resets_high(k) ? {BANK_W{1'b1}} : {BANK_W{1'b0}})
         ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we_kind[k]),
            .wdata (wdata),
            .q     (view[k])
         );
      end
   end

   assign level_q = view[int'(KIND_LEVEL)];
   assign dir_q   = view[int'(KIND_DIR)];
   assign inv_q   = view[int'(KIND_INV)];

   // inputs report the (optionally inverted) pin, outputs their last level
   for (genvar i = 0; i < BANK_W; i++) begin : g_state_bit
      assign state_val[i] = dir_q[i] ? (pin_sync[i] ^ inv_q[i]) : level_q[i];
   end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int NUM_BANKS   = 2,
   parameter int BANK_W      = 8,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit READ_REG    = 1'b0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic                          rd_en,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [BANK_W-1:0]             wdata,
   output logic [BANK_W-1:0]             rdata,
   input  logic [NUM_BANKS*BANK_W-1:0]   pad_in,
   output logic [NUM_BANKS*BANK_W-1:0]   pad_out,
   output logic [NUM_BANKS*BANK_W-1:0]   pad_oe,
   output logic [NUM_BANKS*BANK_W-1:0]   pull_en
);

   localparam int NUM_PINS = NUM_BANKS * BANK_W;
   localparam int NUM_REGS = NUM_KINDS * NUM_BANKS;

   if (NUM_BANKS < 1 || BANK_W < 1) begin : g_bad_shape
      $error("gpio_port_regs: NUM_BANKS and BANK_W must be positive");
   end
   if (NUM_REGS > (1 << ADDR_W)) begin : g_bad_addr
      $error("gpio_port_regs: ADDR_W too narrow for the register map");
   end

   logic [NUM_PINS-1:0]                                pin_sync;
   logic [NUM_BANKS-1:0][NUM_KINDS-1:1]                we;
   logic [NUM_BANKS-1:0][NUM_KINDS-1:0][BANK_W-1:0]    view_all;
   logic [BANK_W-1:0]                                  rd_mux;

   gpio_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pad_in),
      .sync_out (pin_sync)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      for (genvar k = 1; k < NUM_KINDS; k++) begin : g_we
         assign we[b][k] = wr_en && (addr == ADDR_W'(reg_addr(k, b, NUM_BANKS)));
      end

      gpio_bank #(
         .BANK_W (BANK_W)
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .we_kind  (we[b]),
         .wdata    (wdata),
         .pin_sync (pin_sync[b*BANK_W +: BANK_W]),
         .view     (view_all[b])
      );

      assign pad_out[b*BANK_W +: BANK_W] = view_all[b][int'(KIND_LEVEL)];
      assign pad_oe [b*BANK_W +: BANK_W] = ~view_all[b][int'(KIND_DIR)]
                                         & ~view_all[b][int'(KIND_FLOAT)];
      assign pull_en[b*BANK_W +: BANK_W] = view_all[b][int'(KIND_PULL)];
   end

   always_comb begin
      rd_mux = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         for (int k = 0; k < NUM_KINDS; k++) begin
            if (addr == ADDR_W'(reg_addr(k, b, NUM_BANKS))) begin
               rd_mux = view_all[b][k];
            end
         end
      end
   end

   if (READ_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rdata <= '0;
         end else begin
            rdata <= rd_en ? rd_mux : '0;
         end
      end
   end else begin : g_rd_comb
      assign rdata = rd_en ? rd_mux : '0;
   end

endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
   import gpio_port_pkg::*;
#(
   parameter int NUM_BANKS = 2,
   parameter int BANK_W    = 8,
   parameter int ADDR_W    = 4,
   parameter bit READ_REG  = 1'b0
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        wr_en,
   input logic                        rd_en,
   input logic [ADDR_W-1:0]           addr,
   input logic [BANK_W-1:0]           wdata,
   input logic [BANK_W-1:0]           rdata,
   input logic [NUM_BANKS*BANK_W-1:0] pad_out,
   input logic [NUM_BANKS*BANK_W-1:0] pad_oe,
   input logic [NUM_BANKS*BANK_W-1:0] pull_en
);

   localparam logic [ADDR_W-1:0] A_STATE0 = ADDR_W'(reg_addr(int'(KIND_STATE), 0, NUM_BANKS));
   localparam logic [ADDR_W-1:0] A_LEVEL0 = ADDR_W'(reg_addr(int'(KIND_LEVEL), 0, NUM_BANKS));
   localparam logic [ADDR_W-1:0] A_FLOAT0 = ADDR_W'(reg_addr(int'(KIND_FLOAT), 0, NUM_BANKS));
   localparam logic [ADDR_W-1:0] A_PULL0  = ADDR_W'(reg_addr(int'(KIND_PULL), 0, NUM_BANKS));

   logic pull_hit;
   always_comb begin
      pull_hit = 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (addr == ADDR_W'(reg_addr(int'(KIND_PULL), b, NUM_BANKS))) pull_hit = 1'b1;
      end
   end

   // R1: the first edge out of reset shows inputs only, pull-ups off
   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pad_oe == '0 && pull_en == '0 && pad_out == '1));

   // R5: a level write appears on pad_out one cycle later
   assert_level_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_LEVEL0) |=> (pad_out[BANK_W-1:0] == $past(wdata)));

   // R4: floating every pin of bank 0 removes all drive there
   assert_float_kills_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_FLOAT0 && wdata == '1) |=> (pad_oe[BANK_W-1:0] == '0));

   // R8: pull-ups move only through a write to a pull-up address
   assert_pull_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && pull_hit) |=> $stable(pull_en));

   // R8: a bank 0 pull-up write shows directly on pull_en
   assert_pull_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_PULL0) |=> (pull_en[BANK_W-1:0] == $past(wdata)));

   // R9: a write to the read-only state address leaves the pins alone
   assert_state_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_STATE0) |=> ($stable(pad_out) && $stable(pad_oe) && $stable(pull_en)));

   if (!READ_REG) begin : g_comb_checks
      // R7: driven pins of bank 0 read back their level, not the pad
      assert_out_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && addr == A_STATE0 && pad_oe[BANK_W-1:0] == '1) |-> (rdata == pad_out[BANK_W-1:0]));
      // R9: idle read port returns zero
      assert_idle_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_en |-> (rdata == '0));
   end

endmodule

bind gpio_port_regs gpio_port_regs_chk #(
   .NUM_BANKS (NUM_BANKS),
   .BANK_W    (BANK_W),
   .ADDR_W    (ADDR_W),
   .READ_REG  (READ_REG)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .rd_en   (rd_en),
   .addr    (addr),
   .wdata   (wdata),
   .rdata   (rdata),
   .pad_out (pad_out),
   .pad_oe  (pad_oe),
   .pull_en (pull_en)
);

// File: tb/tb_gpio_port_regs.sv
`timescale 1ns/1ps
module tb_gpio_port_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [15:0] pad_in = '0;
   logic [15:0] pad_out, pad_oe, pull_en;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   // address map: kind*2 + bank
   localparam logic [3:0] ST0 = 4'd0, ST1 = 4'd1, LV0 = 4'd2, LV1 = 4'd3,
                          DR0 = 4'd4, DR1 = 4'd5, FL0 = 4'd6, FL1 = 4'd7,
                          IV0 = 4'd8, IV1 = 4'd9, PU0 = 4'd10, PU1 = 4'd11;

   always #5 clk = ~clk;

   gpio_port_regs dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
      .pad_oe(pad_oe), .pull_en(pull_en)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic write_reg(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic read_reg(input logic [3:0] a, output logic [7:0] d);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      rd_en = 1'b0;
   endtask

   task automatic check_reg(input string req, input logic [3:0] a, input logic [7:0] exp);
      logic [7:0] d;
      read_reg(a, d);
      check(req, {24'd0, d}, {24'd0, exp});
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1 pad_oe", {16'd0, pad_oe}, 32'h0);
      check("R1 pull_en", {16'd0, pull_en}, 32'h0);
      check("R1 pad_out", {16'd0, pad_out}, 32'hFFFF);
      check_reg("R1 dir0", DR0, 8'hFF);
      check_reg("R1 level1", LV1, 8'hFF);
      check_reg("R1 float0", FL0, 8'h00);
      check_reg("R1 inv1", IV1, 8'h00);
      check_reg("R1 pull0", PU0, 8'h00);
   endtask

   task automatic t_map;
      write_reg(LV0, 8'h5A);
      write_reg(LV1, 8'hC3);
      check("R2 level map", {16'd0, pad_out}, 32'hC35A);
      check_reg("R2 readback level0", LV0, 8'h5A);
      write_reg(PU1, 8'h81);
      check("R2 pull bank1 msb/lsb", {16'd0, pull_en}, 32'h8100);
      write_reg(PU1, 8'h00);
   endtask

   task automatic t_dir;
      write_reg(DR0, 8'h0F);
      check("R3 bank0 upper outputs", {16'd0, pad_oe}, 32'h00F0);
      write_reg(DR1, 8'h00);
      check("R3 bank1 all outputs", {16'd0, pad_oe}, 32'hFFF0);
   endtask

   task automatic t_float;
      write_reg(FL1, 8'hF0);
      check("R4 float clears oe", {16'd0, pad_oe}, 32'h0FF0);
      check("R4 pad_out kept", {16'd0, pad_out}, 32'hC35A);
      check_reg("R4 float1 readback", FL1, 8'hF0);
      write_reg(FL1, 8'h00);
   endtask

   task automatic t_level;
      write_reg(LV0, 8'h3C);
      check("R5 pad_out low", {24'd0, pad_out[7:0]}, 32'h3C);
      check_reg("R5 level readback", LV0, 8'h3C);
   endtask

   task automatic t_state_in;
      logic [7:0] d;
      write_reg(DR0, 8'hFF);
      write_reg(DR1, 8'hFF);
      write_reg(IV0, 8'h00);
      pad_in = 16'h0000;
      repeat (3) @(negedge clk);
      pad_in = 16'hA53C;
      @(negedge clk);
      read_reg(ST0, d);
      check("R6 one edge not yet", {24'd0, d}, 32'h00);
      @(negedge clk);
      read_reg(ST0, d);
      check("R6 two edges visible", {24'd0, d}, 32'h3C);
      check_reg("R6 bank1 state", ST1, 8'hA5);
      write_reg(IV0, 8'hFF);
      check_reg("R6 inverted", ST0, 8'hC3);
      write_reg(IV0, 8'h00);
   endtask

   task automatic t_state_out;
      write_reg(DR0, 8'h00);
      write_reg(LV0, 8'h96);
      write_reg(IV0, 8'hFF);
      pad_in[7:0] = 8'h00;
      repeat (3) @(negedge clk);
      check_reg("R7 outputs report level", ST0, 8'h96);
      write_reg(IV0, 8'h00);
      write_reg(DR0, 8'hF0);
      write_reg(LV0, 8'h05);
      pad_in[7:0] = 8'hA0;
      repeat (3) @(negedge clk);
      check_reg("R7 mixed pins", ST0, 8'hA5);
   endtask

   task automatic t_pull;
      write_reg(PU0, 8'h3C);
      write_reg(PU1, 8'h01);
      check("R8 pull set", {16'd0, pull_en}, 32'h013C);
      write_reg(PU0, 8'h00);
      check("R8 pull cleared", {16'd0, pull_en}, 32'h0100);
   endtask

   task automatic t_ignore;
      logic [15:0] o_out, o_oe, o_pu;
      logic [7:0] d;
      o_out = pad_out; o_oe = pad_oe; o_pu = pull_en;
      write_reg(ST0, 8'hFF);
      write_reg(ST1, 8'h00);
      for (int a = 12; a < 16; a++) write_reg(4'(a), 8'h00);
      check("R9 pad_out kept", {16'd0, pad_out}, {16'd0, o_out});
      check("R9 pad_oe kept", {16'd0, pad_oe}, {16'd0, o_oe});
      check("R9 pull_en kept", {16'd0, pull_en}, {16'd0, o_pu});
      check_reg("R9 dir0 kept", DR0, 8'hF0);
      check_reg("R9 level0 kept", LV0, 8'h05);
      check_reg("R9 unmapped reads zero", 4'd13, 8'h00);
      addr = LV0; rd_en = 1'b0;
      #1 d = rdata;
      check("R9 idle rdata", {24'd0, d}, 32'h0);
   endtask

   task automatic t_same_cycle;
      logic [7:0] d;
      write_reg(LV1, 8'h11);
      @(negedge clk);
      wr_en = 1'b1; rd_en = 1'b1; addr = LV1; wdata = 8'h77;
      #1 d = rdata;
      check("R10 old value same cycle", {24'd0, d}, 32'h11);
      @(negedge clk);
      wr_en = 1'b0;
      #1 d = rdata;
      rd_en = 1'b0;
      check("R10 new value next cycle", {24'd0, d}, 32'h77);
      check("R10 pad_out high", {24'd0, pad_out[15:8]}, 32'h77);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_map();
      t_dir();
      t_float();
      t_level();
      t_state_in();
      t_state_out();
      t_pull();
      t_ignore();
      t_same_cycle();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule